// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block turns a 3-bit source code into a one-cycle count-enable for a timer/counter. Everything runs on the system clock. The code picks one of three kinds of source:

- **Stopped:** no enable is produced.
- **Divided system clock:** taps at 1, 8, 64, 256 and 1024. The four slower taps come from one shared prescaler counter that never stops.
- **External pin:** either its rising or its falling transitions.

The external pin is read through its input path whatever direction the pad is driving. Software that toggles the pin as an output can therefore step the timer.

The enable is registered. A new source code takes effect from the cycle after it is sampled. A prescaler-clear input zeroes the shared counter. This puts a divided enable exactly N cycles after the clearing edge, so the timer phase can be aligned with an outside event.

The external pin passes through a two-flop synchronizer, and its edges are detected in the system clock domain. Each edge of the selected polarity gives exactly one enable pulse, three clock edges after the pin changes.

Top module: `tmr_clk_sel`

## Requirements
- R1: Source code 3'b000 never asserts `cnt_en`, whatever `ext_clk` and `pre_clr` do.
- R2: Source code 3'b001 asserts `cnt_en` in every cycle that follows a rising clock edge at which the code was sampled.
- R3: Source codes 3'b010, 3'b011, 3'b100 and 3'b101 give one-cycle pulses on `cnt_en`, with a period of 8, 64, 256 and 1024 clocks respectively.
- R4: The prescaler keeps counting in every source mode, and changing the code does not restart it. A divided pulse appears in the cycle after the (8k)-th, (64k)-th, (256k)-th or (1024k)-th rising edge counted from the last clear or reset, where k is a positive integer. For example, switching to 3'b010 ten edges after a clear gives the first pulse after edge 16.
- R5: When `pre_clr` is sampled high at a rising edge, that edge produces no divided pulse. The next divided pulse follows the N-th edge after it.
- R6: Source code 3'b110 gives exactly one `cnt_en` pulse for each falling transition of `ext_clk`. The pulse is high in the cycle after the third rising edge following the transition.
- R7: Source code 3'b111 gives exactly one `cnt_en` pulse for each rising transition of `ext_clk`, with the same three-edge latency.
- R8: In either pin mode, a transition of the polarity that was not selected produces no pulse.
- R9: While `rst_n` is low, `cnt_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Count source code (see R1 to R8) |
| ext_clk | input | 1 | External count pin, asynchronous to `clk` |
| pre_clr | input | 1 | Synchronous clear of the shared prescaler |
| cnt_en | output | 1 | One-cycle count-enable for the timer |

## Verification
The properties assume that `clk_sel` and `pre_clr` are synchronous to `clk`. The bench drives them only on the falling edge.

They also assume that `ext_clk` holds each level for at least two clock cycles, so that the synchronizer does not merge two transitions. The bench holds every pin level for six cycles or more.

Finally, the properties assume that `ext_clk` is low while reset is released. The bench keeps the pin low until reset is released, so no startup edge is seen.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [2:0] {
    SRC_OFF      = 3'd0,
    SRC_DIRECT   = 3'd1,
    SRC_DIV8     = 3'd2,
    SRC_DIV64    = 3'd3,
    SRC_DIV256   = 3'd4,
    SRC_DIV1024  = 3'd5,
    SRC_PIN_FALL = 3'd6,
    SRC_PIN_RISE = 3'd7
  } src_sel_e;

  localparam int NUM_TAPS = 4;

  // log2 of the divide ratio of each shared prescaler tap
  function automatic int tap_shift(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  function automatic logic is_divided(input logic [2:0] sel);
    return (sel >= 3'd2) && (sel <= 3'd5);
  endfunction

  // tap chosen by a divided source code
  function automatic logic tap_pick(input logic [NUM_TAPS-1:0] taps,
                                    input logic [2:0] sel);
    logic [2:0] k;
    k = sel - 3'd2;
    return taps[k[1:0]];
  endfunction

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler
  import tcs_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  output logic [NUM_TAPS-1:0] tap_hit
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_q + STEP;
  end

  // a tap fires when its low count bits are all ones; a clearing cycle mutes it
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int SH = tap_shift(i);
    assign tap_hit[i] = (&cnt_q[SH-1:0]) & ~clr;
  end

endmodule

// File: rtl/tcs_pin_edge.sv
module tcs_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
  assign fall = ~sync_q[STAGES-1] & last_q;

endmodule

// File: rtl/tcs_src_mux.sv
module tcs_src_mux
  import tcs_pkg::*;
(
  input  logic [2:0]          sel,
  input  logic [NUM_TAPS-1:0] tap_hit,
  input  logic                rise,
  input  logic                fall,
  output logic                en_next
);

  always_comb begin
    unique case (src_sel_e'(sel))
      SRC_OFF:      en_next = 1'b0;
      SRC_DIRECT:   en_next = 1'b1;
      SRC_PIN_FALL: en_next = fall;
      SRC_PIN_RISE: en_next = rise;
      default:      en_next = tap_pick(tap_hit, sel);
    endcase
  end

endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
  import tcs_pkg::*;
#(
  parameter int PRESC_W     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel,
  input  logic       ext_clk,
  input  logic       pre_clr,
  output logic       cnt_en
);

  // named internal events, observed by the bound checker
  logic [NUM_TAPS-1:0] tap_hit;
  logic                pin_rise;
  logic                pin_fall;
  logic                en_next;

  tcs_prescaler #(.CNT_W(PRESC_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (pre_clr),
    .tap_hit (tap_hit)
  );

  tcs_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (ext_clk),
    .rise  (pin_rise),
    .fall  (pin_fall)
  );

  tcs_src_mux u_mux (
    .sel     (clk_sel),
    .tap_hit (tap_hit),
    .rise    (pin_rise),
    .fall    (pin_fall),
    .en_next (en_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_en <= 1'b0;
    else        cnt_en <= en_next;
  end

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker
  import tcs_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          clk_sel,
  input logic                pre_clr,
  input logic                cnt_en,
  input logic [NUM_TAPS-1:0] tap_hit,
  input logic                pin_rise,
  input logic                pin_fall
);

  logic [1:0] warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= 2'b00;
    else        warm_q <= {warm_q[0], 1'b1};
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !cnt_en);  // R9

  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q[0] && $past(clk_sel) == 3'd0) |-> !cnt_en);  // R1

  AST_DIRECT_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q[0] && $past(clk_sel) == 3'd1) |-> cnt_en);  // R2

  AST_DIV_FROM_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q[0] && cnt_en && is_divided($past(clk_sel)))
      |-> tap_pick($past(tap_hit), $past(clk_sel)));  // R3

  AST_DIV_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q[1] && cnt_en && $past(cnt_en) && is_divided($past(clk_sel)))
      |-> !is_divided($past(clk_sel, 2)));  // R3

  AST_CLEAR_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q[0] && $past(pre_clr) && is_divided($past(clk_sel))) |-> !cnt_en);  // R5

  AST_FALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q[0] && $past(clk_sel) == 3'd6) |-> (cnt_en == $past(pin_fall)));  // R6

  AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q[0] && $past(clk_sel) == 3'd7) |-> (cnt_en == $past(pin_rise)));  // R7

endmodule

bind tmr_clk_sel tcs_checker u_tcs_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_sel  (clk_sel),
  .pre_clr  (pre_clr),
  .cnt_en   (cnt_en),
  .tap_hit  (tap_hit),
  .pin_rise (pin_rise),
  .pin_fall (pin_fall)
);

// File: tb/tmr_clk_sel_bench.sv
module tmr_clk_sel_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic       ext_clk = 1'b0;
  logic       pre_clr = 1'b0;
  logic       cnt_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  tmr_clk_sel u_tmr_clk_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_sel (clk_sel),
    .ext_clk (ext_clk),
    .pre_clr (pre_clr),
    .cnt_en  (cnt_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance n rising edges, then settle on the following falling edge
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // count enable pulses over n cycles
  task automatic count_pulses(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (cnt_en) hits++;
    end
  endtask

  // one clearing edge; returns on the falling edge just after it
  task automatic do_clear();
    pre_clr = 1'b1;
    tick(1);
    pre_clr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cnt_en, 1'b0, "R9 enable low in reset");
    tick(3);
    chk(cnt_en, 1'b0, "R9 enable still low in reset");
    rst_n = 1'b1;
    tick(2);
    chk(cnt_en, 1'b0, "R1 stopped after reset");
  endtask

  task automatic t_stop();
    int hits;
    hits = 0;
    clk_sel = 3'd0;
    for (int i = 0; i < 40; i++) begin
      if (i % 6 == 0) ext_clk = ~ext_clk;
      pre_clr = (i % 11 == 0);
      tick(1);
      if (cnt_en) hits++;
    end
    pre_clr = 1'b0;
    ext_clk = 1'b0;
    tick(4);
    chk_int(hits, 0, "R1 no enable in stopped mode");
  endtask

  task automatic t_direct();
    clk_sel = 3'd1;
    for (int i = 0; i < 5; i++) begin
      tick(1);
      chk(cnt_en, 1'b1, "R2 enable every cycle");
    end
    clk_sel = 3'd0;
    tick(1);
    chk(cnt_en, 1'b0, "R1 stop after direct");
  endtask

  task automatic t_div(input logic [2:0] code, input int n);
    clk_sel = code;
    do_clear();
    tick(n - 1);
    chk(cnt_en, 1'b0, $sformatf("R5 no pulse before edge %0d", n));
    tick(1);
    chk(cnt_en, 1'b1, $sformatf("R3 first pulse divide %0d", n));
    tick(1);
    chk(cnt_en, 1'b0, $sformatf("R3 one-cycle pulse divide %0d", n));
    tick(n - 2);
    chk(cnt_en, 1'b0, $sformatf("R3 gap divide %0d", n));
    tick(1);
    chk(cnt_en, 1'b1, $sformatf("R3 second pulse divide %0d", n));
  endtask

  task automatic t_window();
    int hits;
    clk_sel = 3'd3;
    do_clear();
    count_pulses(256, hits);
    chk_int(hits, 4, "R3 four pulses per 256 cycles at divide 64");
  endtask

  task automatic t_free_run();
    clk_sel = 3'd0;
    do_clear();
    tick(10);
    clk_sel = 3'd2;
    tick(5);
    chk(cnt_en, 1'b0, "R4 no pulse at edge 15");
    tick(1);
    chk(cnt_en, 1'b1, "R4 pulse keeps phase at edge 16");
  endtask

  task automatic t_clear_mid();
    clk_sel = 3'd2;
    do_clear();
    tick(7);        // prescaler low bits now all ones
    pre_clr = 1'b1;
    tick(1);
    pre_clr = 1'b0;
    chk(cnt_en, 1'b0, "R5 clearing edge gives no pulse");
    tick(7);
    chk(cnt_en, 1'b0, "R5 no pulse at edge 7 after clear");
    tick(1);
    chk(cnt_en, 1'b1, "R5 pulse 8 edges after clear");
  endtask

  task automatic t_pin(input logic [2:0] code, input logic idle, input string req);
    int hits;
    clk_sel = code;
    ext_clk = idle;
    tick(8);
    for (int rep = 0; rep < 2; rep++) begin
      ext_clk = ~idle;
      tick(2);
      chk(cnt_en, 1'b0, {req, " no pulse before third edge"});
      tick(1);
      chk(cnt_en, 1'b1, {req, " pulse after third edge"});
      tick(1);
      chk(cnt_en, 1'b0, {req, " pulse lasts one cycle"});
      tick(3);
      ext_clk = idle;
      count_pulses(8, hits);
      chk_int(hits, 0, "R8 opposite transition ignored");
    end
  endtask

  initial begin
    t_reset();
    t_stop();
    t_direct();
    t_div(3'd2, 8);
    t_div(3'd3, 64);
    t_div(3'd4, 256);
    t_div(3'd5, 1024);
    t_window();
    t_free_run();
    t_clear_mid();
    t_pin(3'd6, 1'b1, "R6 falling mode");
    t_pin(3'd7, 1'b0, "R7 rising mode");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule